// File: doc/BRIEF.md
# UART Channel FIFO Pair with Trigger-Level Requests

This block holds the two byte queues of one asynchronous serial channel: a 16-entry transmit queue, which the host fills and the serializer drains, and a 16-entry receive queue, which the deserializer fills and the host drains. It also produces two level-sensitive service requests from the queue fill levels. The request thresholds are programmable.

A single configuration write carries the following fields:
- a queue enable bit;
- one clear bit for each queue;
- a DMA mode bit, which the block only stores and exports;
- two 2-bit threshold codes.

The transmit threshold code is accepted only while the extended-feature input is high. Each clear bit resets only its own queue's pointers, and only when the same write also sets the enable bit.

The transmit request is aware of how the queue was refilled. It fires when the fill drops below the threshold, but only if the last refill took the fill above the threshold. Otherwise it waits until the queue is empty.

Top module: `uart_fifo_trig`

## Requirements
- R1: Each queue holds 16 bytes in first-in first-out order. Its count output gives the number held. The empty flag is high at count 0 and the full flag is high at count 16. A push and a pop in the same cycle on a full queue are both accepted.
- R2: While rst_n is low at a clock edge, the following are cleared: both queues, the overrun flag, both requests, both data outputs, both threshold codes (code 00), fifo_en and dma_mode.
- R3: A configuration write with cfg_rx_clr (or cfg_tx_clr) set empties that queue at the next edge, but only when cfg_fifo_en is 1 in the same write. A clear ignores any push or pop on that queue in the same cycle. It leaves the other queue and that queue's read-data output unchanged. fifo_en follows the last written cfg_fifo_en.
- R4: The receive threshold code maps 00, 01, 10 and 11 to levels 1, 4, 8 and 14. Every configuration write stores the code, which is read back on rx_lvl_q. rx_req is high exactly while rx_count is at or above the level.
- R5: The transmit threshold code uses the same mapping. A configuration write stores it only while xfeat_en is 1; otherwise tx_lvl_q keeps its value.
- R6: A push that leaves tx_count strictly above the transmit level arms the queue. A pop that leaves an armed queue below the level raises tx_req on the next cycle and disarms it.
- R7: A pop that leaves the transmit queue empty raises tx_req, whether or not the queue was armed.
- R8: Any accepted transmit push, and any transmit clear, drops tx_req on the next cycle. A transmit clear also disarms the queue.
- R9: A push to a full receive queue without a pop in the same cycle is dropped and sets rx_overrun. rx_overrun stays set until a receive clear.
- R10: A pop from an empty queue leaves the count and the read-data output unchanged. A pop from a non-empty queue presents the oldest byte on the read-data output after the edge.
- R11: Every configuration write stores cfg_dma, and dma_mode shows it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | Queue enable bit of the write |
| cfg_rx_clr | input | 1 | Receive queue clear bit |
| cfg_tx_clr | input | 1 | Transmit queue clear bit |
| cfg_dma | input | 1 | DMA mode bit |
| cfg_tx_lvl | input | 2 | Transmit threshold code |
| cfg_rx_lvl | input | 2 | Receive threshold code |
| xfeat_en | input | 1 | Extended-feature enable; gates transmit code writes |
| tx_push | input | 1 | Transmit queue write |
| tx_wdata | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Transmit queue read (serializer side) |
| tx_rdata | output | 8 | Last byte read from the transmit queue |
| rx_push | input | 1 | Receive queue write (deserializer side) |
| rx_wdata | input | 8 | Receive byte in |
| rx_pop | input | 1 | Receive queue read |
| rx_rdata | output | 8 | Last byte read from the receive queue |
| tx_count | output | 5 | Transmit fill |
| rx_count | output | 5 | Receive fill |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky receive overrun |
| fifo_en | output | 1 | Stored enable bit |
| dma_mode | output | 1 | Stored DMA mode bit |
| tx_lvl_q | output | 2 | Stored transmit threshold code |
| rx_lvl_q | output | 2 | Stored receive threshold code |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |

## Verification
The assertions assume the following about the inputs:
- rst_n is held low across the first clock edge;
- every input is stable around each rising edge;
- push and pop may arrive in any combination, including on full or empty queues and together with clears, and the guarded properties still hold.

The stimulus meets these assumptions because all inputs change only on the falling edge. Random push and pop rates are varied by phase, so that both queues spend time full and empty. Configuration writes are mixed in with random clear, enable and xfeat_en values, so both the gated and the accepted cases of clears and transmit code writes occur.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
   localparam int unsigned BYTE_W = 8;

   // threshold code to fill level
   function automatic int unsigned lvl_of(input logic [1:0] code);
      int unsigned v;
      unique case (code)
         2'b00:   v = 1;
         2'b01:   v = 4;
         2'b10:   v = 8;
         default: v = 14;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned WIDTH     = 8,
   parameter bit          TRACK_OVR = 1'b0,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    cnt,
   output logic             empty,
   output logic             full,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             ovr
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ufc_byte_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign pop_ok  = pop && !empty && !clr;
   assign push_ok = push && !clr && (!full || pop_ok);

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         cnt  <= '0;
         dout <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + AW'(1);
         if (pop_ok) begin
            dout <= mem[rp];
            rp   <= rp + AW'(1);
         end
         if (push_ok && !pop_ok)      cnt <= cnt + CW'(1);
         else if (pop_ok && !push_ok) cnt <= cnt - CW'(1);
      end
   end

   if (TRACK_OVR) begin : g_ovr
      logic ovr_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                 ovr_q <= 1'b0;
         else if (clr)               ovr_q <= 1'b0;
         else if (push && !push_ok)  ovr_q <= 1'b1;
      end
      assign ovr = ovr_q;

      assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ovr && !clr |=> ovr);
   end else begin : g_no_ovr
      assign ovr = 1'b0;
   end

   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);
   assert_clear_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> $stable(dout));
   assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      empty && pop && !push && !clr |=> empty && $stable(dout));
endmodule

// File: rtl/ufc_tx_req.sv
module ufc_tx_req #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push_ok,
   input  logic          pop_ok,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] lvl,
   output logic          req
);
   logic          armed;
   logic [CW-1:0] nxt;

   always_comb begin
      nxt = cnt;
      if (push_ok && !pop_ok)      nxt = cnt + CW'(1);
      else if (pop_ok && !push_ok) nxt = cnt - CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         req   <= 1'b0;
         armed <= 1'b0;
      end else if (push_ok) begin
         req <= 1'b0;
         if (nxt > lvl) armed <= 1'b1;
      end else if (pop_ok && ((armed && nxt < lvl) || nxt == '0)) begin
         req   <= 1'b1;
         armed <= 1'b0;
      end
   end

   assert_push_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> !req);
   assert_req_needs_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_ok |=> !$rose(req));
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic          cfg_fifo_en,
   input  logic          cfg_rx_clr,
   input  logic          cfg_tx_clr,
   input  logic          cfg_dma,
   input  logic [1:0]    cfg_tx_lvl,
   input  logic [1:0]    cfg_rx_lvl,
   input  logic          xfeat_en,
   input  logic          tx_push,
   input  logic [7:0]    tx_wdata,
   input  logic          tx_pop,
   output logic [7:0]    tx_rdata,
   input  logic          rx_push,
   input  logic [7:0]    rx_wdata,
   input  logic          rx_pop,
   output logic [7:0]    rx_rdata,
   output logic [CW-1:0] tx_count,
   output logic [CW-1:0] rx_count,
   output logic          tx_empty,
   output logic          tx_full,
   output logic          rx_empty,
   output logic          rx_full,
   output logic          rx_overrun,
   output logic          fifo_en,
   output logic          dma_mode,
   output logic [1:0]    tx_lvl_q,
   output logic [1:0]    rx_lvl_q,
   output logic          tx_req,
   output logic          rx_req
);
   import uart_fifo_pkg::*;

   if (DEPTH < 14) begin : g_bad_depth
      $error("uart_fifo_trig: DEPTH must cover the highest threshold of 14");
   end

   logic          tx_clr, rx_clr;
   logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok, tx_ovr_unused;
   logic [CW-1:0] tx_lvl, rx_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_en  <= 1'b0;
         dma_mode <= 1'b0;
         tx_lvl_q <= 2'b00;
         rx_lvl_q <= 2'b00;
      end else if (cfg_wr) begin
         fifo_en  <= cfg_fifo_en;
         dma_mode <= cfg_dma;
         rx_lvl_q <= cfg_rx_lvl;
         if (xfeat_en) tx_lvl_q <= cfg_tx_lvl;
      end
   end

   assign tx_clr = cfg_wr && cfg_fifo_en && cfg_tx_clr;
   assign rx_clr = cfg_wr && cfg_fifo_en && cfg_rx_clr;
   assign tx_lvl = CW'(lvl_of(tx_lvl_q));
   assign rx_lvl = CW'(lvl_of(rx_lvl_q));

   ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .TRACK_OVR(1'b0)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(tx_push), .din(tx_wdata), .pop(tx_pop), .dout(tx_rdata),
      .cnt(tx_count), .empty(tx_empty), .full(tx_full),
      .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .ovr(tx_ovr_unused));

   ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .TRACK_OVR(1'b1)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(rx_push), .din(rx_wdata), .pop(rx_pop), .dout(rx_rdata),
      .cnt(rx_count), .empty(rx_empty), .full(rx_full),
      .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .ovr(rx_overrun));

   ufc_tx_req #(.CW(CW)) u_tx_req (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
      .cnt(tx_count), .lvl(tx_lvl), .req(tx_req));

   assign rx_req = (rx_count >= rx_lvl);

   assert_txlvl_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && !xfeat_en |=> $stable(tx_lvl_q));
   assert_clr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && !cfg_fifo_en && !rx_pop |=> rx_count >= $past(rx_count));
   assert_clr_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr && !tx_clr && !tx_push && !tx_pop |=> $stable(tx_count));
   assert_dma_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> dma_mode == $past(cfg_dma));
   assert_rx_full_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> rx_req);
endmodule

// File: tb/uart_fifo_trig_bench.sv
`timescale 1ns/100ps
module uart_fifo_trig_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 0, cfg_fifo_en = 0, cfg_rx_clr = 0, cfg_tx_clr = 0, cfg_dma = 0;
   logic [1:0] cfg_tx_lvl = 0, cfg_rx_lvl = 0;
   logic       xfeat_en = 0;
   logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
   logic [7:0] tx_wdata = 0, rx_wdata = 0;
   logic [7:0] tx_rdata, rx_rdata;
   logic [4:0] tx_count, rx_count;
   logic       tx_empty, tx_full, rx_empty, rx_full, rx_overrun;
   logic       fifo_en, dma_mode, tx_req, rx_req;
   logic [1:0] tx_lvl_q, rx_lvl_q;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   int m_tq[$], m_rq[$];
   int m_tdout, m_rdout, m_tcode, m_rcode;
   bit m_en, m_dma, m_ovr, m_treq, m_tarm;

   uart_fifo_trig u_uart_fifo_trig (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en),
      .cfg_rx_clr(cfg_rx_clr), .cfg_tx_clr(cfg_tx_clr), .cfg_dma(cfg_dma),
      .cfg_tx_lvl(cfg_tx_lvl), .cfg_rx_lvl(cfg_rx_lvl), .xfeat_en(xfeat_en),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .tx_count(tx_count), .rx_count(rx_count), .tx_empty(tx_empty), .tx_full(tx_full),
      .rx_empty(rx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun),
      .fifo_en(fifo_en), .dma_mode(dma_mode), .tx_lvl_q(tx_lvl_q), .rx_lvl_q(rx_lvl_q),
      .tx_req(tx_req), .rx_req(rx_req));

   always #2.5 clk = ~clk;

   function automatic int lvl(input int code);
      case (code)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit tclr, rclr, pop_ok, push_ok;
      int tl, n;
      if (!rst_n) begin
         m_tq.delete(); m_rq.delete();
         m_tdout = 0; m_rdout = 0; m_tcode = 0; m_rcode = 0;
         m_en = 0; m_dma = 0; m_ovr = 0; m_treq = 0; m_tarm = 0;
         return;
      end
      tclr = cfg_wr && cfg_fifo_en && cfg_tx_clr;
      rclr = cfg_wr && cfg_fifo_en && cfg_rx_clr;
      tl = lvl(m_tcode);
      if (tclr) begin
         m_tq.delete(); m_treq = 0; m_tarm = 0;
      end else begin
         pop_ok  = tx_pop && m_tq.size() > 0;
         push_ok = tx_push && (m_tq.size() < 16 || pop_ok);
         if (pop_ok) m_tdout = m_tq.pop_front();
         if (push_ok) m_tq.push_back(int'(tx_wdata));
         n = m_tq.size();
         if (push_ok) begin
            m_treq = 0;
            if (n > tl) m_tarm = 1;
         end else if (pop_ok && ((m_tarm && n < tl) || n == 0)) begin
            m_treq = 1; m_tarm = 0;
         end
      end
      if (rclr) begin
         m_rq.delete(); m_ovr = 0;
      end else begin
         pop_ok  = rx_pop && m_rq.size() > 0;
         push_ok = rx_push && (m_rq.size() < 16 || pop_ok);
         if (pop_ok) m_rdout = m_rq.pop_front();
         if (push_ok) m_rq.push_back(int'(rx_wdata));
         if (rx_push && !push_ok) m_ovr = 1;
      end
      if (cfg_wr) begin
         m_en = cfg_fifo_en; m_dma = cfg_dma; m_rcode = cfg_rx_lvl;
         if (xfeat_en) m_tcode = cfg_tx_lvl;
      end
   endtask

   task automatic compare_all();
      chk("R1 tx_count", tx_count, m_tq.size());
      chk("R1 rx_count", rx_count, m_rq.size());
      chk("R1 tx_empty", tx_empty, m_tq.size() == 0);
      chk("R1 tx_full", tx_full, m_tq.size() == 16);
      chk("R1 rx_empty", rx_empty, m_rq.size() == 0);
      chk("R1 rx_full", rx_full, m_rq.size() == 16);
      chk("R10 tx_rdata", tx_rdata, m_tdout);
      chk("R10 rx_rdata", rx_rdata, m_rdout);
      chk("R9 rx_overrun", rx_overrun, m_ovr);
      chk("R3 fifo_en", fifo_en, m_en);
      chk("R11 dma_mode", dma_mode, m_dma);
      chk("R5 tx_lvl_q", tx_lvl_q, m_tcode);
      chk("R4 rx_lvl_q", rx_lvl_q, m_rcode);
      chk("R4 rx_req", rx_req, m_rq.size() >= lvl(m_rcode));
      chk("R6/R7/R8 tx_req", tx_req, m_treq);
   endtask

   // inputs are set at the falling edge; the model and the checks run 1 ns after the rising edge
   task automatic cyc();
      @(posedge clk);
      model_step();
      #1;
      compare_all();
      @(negedge clk);
   endtask

   task automatic idle();
      cfg_wr = 0; cfg_fifo_en = 0; cfg_rx_clr = 0; cfg_tx_clr = 0;
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
   endtask

   task automatic cfg(input bit en, input bit rc, input bit tc, input bit dma,
                      input int tcode, input int rcode, input bit xf);
      idle();
      cfg_wr = 1; cfg_fifo_en = en; cfg_rx_clr = rc; cfg_tx_clr = tc; cfg_dma = dma;
      cfg_tx_lvl = 2'(tcode); cfg_rx_lvl = 2'(rcode); xfeat_en = xf;
      cyc();
      idle();
   endtask

   task automatic tpush(input int k);
      for (int i = 0; i < k; i++) begin
         idle(); tx_push = 1; tx_wdata = 8'(8'h40 + i); cyc();
      end
      idle();
   endtask

   task automatic tpop(input int k);
      for (int i = 0; i < k; i++) begin
         idle(); tx_pop = 1; cyc();
      end
      idle();
   endtask

   initial begin
      #(5ns * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      cyc(); cyc();
      rst_n = 1;
      // R2: reset state
      chk("R2 tx_count", tx_count, 0);
      chk("R2 rx_count", rx_count, 0);
      chk("R2 tx_lvl_q", tx_lvl_q, 0);
      chk("R2 rx_lvl_q", rx_lvl_q, 0);
      chk("R2 dma_mode", dma_mode, 0);
      chk("R2 fifo_en", fifo_en, 0);
      chk("R2 tx_req", tx_req, 0);
      chk("R2 rx_overrun", rx_overrun, 0);

      // R10: pop from empty
      idle(); tx_pop = 1; rx_pop = 1; cyc(); idle();
      chk("R10 empty pop count", tx_count, 0);

      // R1: fill transmit queue past capacity, then drain in order
      tpush(17);
      chk("R1 full count", tx_count, 16);
      chk("R1 full flag", tx_full, 1);
      idle(); tx_pop = 1; cyc(); idle();
      chk("R1 first out", tx_rdata, 8'h40);
      tpop(15);
      chk("R1 last out", tx_rdata, 8'h4f);

      // R9: overrun on receive
      for (int i = 0; i < 17; i++) begin
         idle(); rx_push = 1; rx_wdata = 8'(i); cyc();
      end
      idle();
      chk("R9 overrun set", rx_overrun, 1);
      idle(); rx_pop = 1; cyc(); idle();
      // R3: clear without enable is ignored
      tpush(3);
      cfg(0, 1, 1, 0, 0, 0, 0);
      chk("R3 gated rx clear", rx_count, 15);
      chk("R3 gated tx clear", tx_count, 3);
      cfg(1, 1, 0, 0, 0, 0, 0);
      chk("R3 rx cleared", rx_count, 0);
      chk("R3 overrun cleared", rx_overrun, 0);
      chk("R3 tx untouched", tx_count, 3);
      chk("R3 rx data kept", rx_rdata, 0);
      cfg(1, 0, 1, 0, 0, 0, 0);
      chk("R8 tx clear drops req", tx_req, 0);

      // R5: transmit code lock
      cfg(1, 0, 0, 0, 2, 1, 0);
      chk("R5 locked", tx_lvl_q, 0);
      chk("R4 rx code", rx_lvl_q, 1);
      cfg(1, 0, 0, 1, 2, 1, 1);
      chk("R5 unlocked", tx_lvl_q, 2);
      chk("R11 dma set", dma_mode, 1);

      // R6: armed refill with level 8
      tpush(10);
      tpop(2);
      chk("R6 at level no req", tx_req, 0);
      tpop(1);
      chk("R6 below level req", tx_req, 1);
      tpush(1);
      chk("R8 push drops req", tx_req, 0);
      tpop(8);
      // R7: shallow refill waits for empty
      tpush(5);
      tpop(4);
      chk("R7 not armed no req", tx_req, 0);
      tpop(1);
      chk("R7 empty req", tx_req, 1);

      // R4: receive request at level 4
      for (int i = 0; i < 4; i++) begin
         idle(); rx_push = 1; rx_wdata = 8'(i + 100); cyc();
      end
      idle();
      chk("R4 rx_req at level", rx_req, 1);
      idle(); rx_pop = 1; cyc(); idle();
      chk("R4 rx_req below", rx_req, 0);

      // random phases
      for (int ph = 0; ph < 8; ph++) begin
         int pp = (ph % 2 == 0) ? 70 : 30;
         for (int c = 0; c < 500; c++) begin
            idle();
            if ($urandom_range(99) < 3) begin
               cfg_wr = 1;
               cfg_fifo_en = 1'($urandom_range(1));
               cfg_rx_clr = ($urandom_range(3) == 0);
               cfg_tx_clr = ($urandom_range(3) == 0);
               cfg_dma = 1'($urandom_range(1));
               cfg_tx_lvl = 2'($urandom_range(3));
               cfg_rx_lvl = 2'($urandom_range(3));
               xfeat_en = 1'($urandom_range(1));
            end
            tx_push = ($urandom_range(99) < pp);
            rx_push = ($urandom_range(99) < pp);
            tx_pop = ($urandom_range(99) < 100 - pp);
            rx_pop = ($urandom_range(99) < 100 - pp);
            tx_wdata = 8'($urandom);
            rx_wdata = 8'($urandom);
            cyc();
         end
      end
      idle();
      cyc();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule